// File: doc/BRIEF.md
# Sample Rate Tracker and Domain Classifier

This block watches a one-cycle strobe that marks the arrival of each audio sample and times the gap between strobes in cycles of a fast reference clock. A first-order recursive average smooths those gaps into a period estimate, so that arrival jitter is filtered out and downstream timing follows only the mean rate. The input rate may lie anywhere between 5 and 55 kHz and is recovered from the strobes alone.

The smoothed period is then sorted into one of four processing bands. The band selects which bass and treble coefficient set the tone filters use. The band edges sit at 12, 25 and 40 kHz, and each edge has a small hysteresis so that the band does not toggle. A lock flag reports a steady input rate. An out-of-range flag reports either a stalled stream or a rate that is too high.

Top module: `sampleRateTracker`

## Requirements
- R1: After reset, periodEst is 0, domain is 0, and locked and outOfRange are both low.
- R2: The gap between two strobes is the number of reference cycles from one sampled strobe to the next. The first strobe after reset or after a timeout only starts timing. The gap that ends at the following strobe is loaded whole as the estimate, and periodEst shows it in the cycle after that strobe.
- R3: Each later gap G updates a 16x scaled accumulator A as A := A - floor(A/16) + G. periodEst is floor(A/16), and it holds between strobes.
- R4: A gap G counts as matching when |G - periodEst| * 50 <= periodEst, with periodEst taken before the update. locked rises after 16 matching gaps in a row. The seeding gap does not count.
- R5: A non-matching gap clears locked and restarts the run of matching gaps.
- R6: domain is the number of band edges the estimate has crossed: 0 for 5-12 kHz, 1 for 12-25 kHz, 2 for 25-40 kHz and 3 for 40-55 kHz. It follows the estimate one cycle later.
- R7: For an edge at E Hz, an uncrossed edge becomes crossed when periodEst <= floor(REF_HZ*100/(E*101)). A crossed edge stays crossed while periodEst <= floor(REF_HZ*100/(E*99)).
- R8: When the reference count since the last strobe (or since reset) exceeds REF_HZ/5000, a timeout occurs. The timeout clears locked and raises outOfRange, and the next strobe only restarts timing. outOfRange from a timeout clears when the next gap seeds the estimate.
- R9: While an estimate is valid and periodEst < floor(REF_HZ/55000), outOfRange is high.
- R10: While no valid estimate exists after a timeout, domain and periodEst hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStrobe | input | 1 | One-cycle pulse per arriving sample, synchronous to clk |
| periodEst | output | PW = $clog2(REF_HZ/5000+2) | Smoothed sample period in reference cycles |
| domain | output | 2 | Processing band, 0 = lowest rate, 3 = highest |
| locked | output | 1 | Input rate steady within 2 percent |
| outOfRange | output | 1 | Stream stalled or rate above 55 kHz |

## Verification
The assertions check every cycle that the gap counter saturates just past the timeout limit, that the estimate changes only on a seed or update strobe, and that a seed loads the gap. They also check that lock rises only after a matching update and drops after a mismatch, that a timeout clears lock and flags out-of-range, that domain holds while no estimate is valid, and that a very short period forces the top band. Only the bench scenarios show the arithmetic of the recursive average under steady and jittered gaps, the 16-gap lock delay, the hysteresis on both sides of the 12 kHz edge, and the boundary between gaps of 960 and 961 cycles at the timeout limit.

// File: rtl/srt_pkg.sv
package srt_pkg;
  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic restart;  // restart the gap counter
    logic seed;     // load the first gap into the estimate
    logic update;   // fold a gap into the running average
  } srtCtl_t;
endpackage

// File: rtl/srtDatapath.sv
module srtDatapath
  import srt_pkg::*;
#(
  parameter int PW          = 14,
  parameter int SHIFT       = 4,
  parameter int TIMEOUT_CYC = 9600,
  parameter int MIN_PER     = 872,
  parameter int TOL_DIV     = 50
) (
  input  logic          clk,
  input  logic          rstN,
  input  srtCtl_t       ctl,
  output logic [PW-1:0] periodEst,
  output logic          periodNear,
  output logic          cntExpired,
  output logic          estTooFast
);
  localparam int QW = PW + SHIFT;
  localparam int SW = PW + 8;
  localparam logic [PW-1:0] CNT_LIMIT = PW'(TIMEOUT_CYC);

  logic [PW-1:0] cnt;
  logic [QW-1:0] estQ;
  logic [PW-1:0] diff;
  logic [SW-1:0] diffScaled;

  assign cntExpired = cnt > CNT_LIMIT;

  // gap counter: saturates one step past the timeout limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.restart) cnt <= PW'(1);
    else if (!cntExpired) cnt <= cnt + PW'(1);
  end

  // scaled first-order recursive average
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) estQ <= '0;
    else if (ctl.seed) estQ <= {cnt, {SHIFT{1'b0}}};
    else if (ctl.update) estQ <= estQ - (estQ >> SHIFT) + QW'(cnt);
  end

  assign periodEst  = estQ[QW-1:SHIFT];
  assign diff       = (cnt >= periodEst) ? (cnt - periodEst) : (periodEst - cnt);
  assign diffScaled = SW'(diff) * SW'(TOL_DIV);
  assign periodNear = diffScaled <= SW'(periodEst);
  assign estTooFast = periodEst < PW'(MIN_PER);

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.seed |=> periodEst == $past(cnt));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LIMIT + PW'(1));

  // R3
  est_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.seed || ctl.update) |=> $stable(estQ));
endmodule

// File: rtl/srtControl.sv
module srtControl
  import srt_pkg::*;
#(
  parameter int LOCK_N = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleStrobe,
  input  logic    periodNear,
  input  logic    cntExpired,
  input  logic    estTooFast,
  output srtCtl_t ctl,
  output logic    estValid,
  output logic    locked,
  output logic    outOfRange
);
  localparam int LCW = $clog2(LOCK_N);
  localparam logic [LCW-1:0] LAST = LCW'(LOCK_N - 1);

  logic           primed;
  logic           timedOut;
  logic [LCW-1:0] lockCnt;
  logic           meas;

  assign meas        = sampleStrobe && primed && !cntExpired;
  assign ctl.restart = sampleStrobe;
  assign ctl.seed    = meas && !estValid;
  assign ctl.update  = meas && estValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      estValid <= 1'b0;
      timedOut <= 1'b0;
      lockCnt  <= '0;
      locked   <= 1'b0;
    end else if (cntExpired) begin
      primed   <= sampleStrobe;
      estValid <= 1'b0;
      timedOut <= 1'b1;
      lockCnt  <= '0;
      locked   <= 1'b0;
    end else if (sampleStrobe) begin
      primed <= 1'b1;
      if (ctl.seed) begin
        estValid <= 1'b1;
        timedOut <= 1'b0;
        lockCnt  <= '0;
        locked   <= 1'b0;
      end else if (ctl.update) begin
        if (periodNear) begin
          if (lockCnt == LAST) locked <= 1'b1;
          else lockCnt <= lockCnt + LCW'(1);
        end else begin
          lockCnt <= '0;
          locked  <= 1'b0;
        end
      end
    end
  end

  assign outOfRange = timedOut || (estValid && estTooFast);

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(ctl.update && periodNear));

  // R5
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.update && !periodNear && !cntExpired) |=> !locked);

  // R8
  expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntExpired |=> (!locked && outOfRange));
endmodule

// File: rtl/srtDomain.sv
module srtDomain #(
  parameter int PW       = 14,
  parameter int REF_HZ   = 48_000_000,
  parameter int EDGE_A   = 12000,
  parameter int EDGE_B   = 25000,
  parameter int EDGE_C   = 40000,
  parameter int HYST_PCT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          estValid,
  input  logic [PW-1:0] periodEst,
  output logic [1:0]    domain
);
  localparam int NB = 3;
  localparam logic [PW-1:0] TOP_UP =
    PW'((longint'(REF_HZ) * 100) / (longint'(EDGE_C) * (100 + HYST_PCT)));

  logic [NB-1:0] crossed;
  logic [1:0]    nextDom;

  for (genvar b = 0; b < NB; b++) begin : g_edge
    localparam longint EDGE = (b == 0) ? longint'(EDGE_A) :
                              (b == 1) ? longint'(EDGE_B) : longint'(EDGE_C);
    localparam logic [PW-1:0] UP_TH =
      PW'((longint'(REF_HZ) * 100) / (EDGE * (100 + HYST_PCT)));
    localparam logic [PW-1:0] DN_TH =
      PW'((longint'(REF_HZ) * 100) / (EDGE * (100 - HYST_PCT)));
    assign crossed[b] = (domain > 2'(b)) ? (periodEst <= DN_TH) : (periodEst <= UP_TH);
  end

  always_comb begin
    nextDom = '0;
    for (int i = 0; i < NB; i++) nextDom = nextDom + 2'(crossed[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) domain <= '0;
    else if (estValid) domain <= nextDom;
  end

  // R10
  dom_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !estValid |=> $stable(domain));

  // R6
  top_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (estValid && periodEst <= TOP_UP) |=> domain == 2'd3);
endmodule

// File: rtl/sampleRateTracker.sv
module sampleRateTracker
  import srt_pkg::*;
#(
  parameter int REF_HZ      = 48_000_000,
  parameter int MIN_RATE_HZ = 5000,
  parameter int MAX_RATE_HZ = 55000,
  parameter int SHIFT       = 4,
  parameter int LOCK_N      = 16,
  parameter int TOL_DIV     = 50,
  parameter int EDGE_A      = 12000,
  parameter int EDGE_B      = 25000,
  parameter int EDGE_C      = 40000,
  parameter int HYST_PCT    = 1,
  localparam int TIMEOUT_CYC = REF_HZ / MIN_RATE_HZ,
  localparam int MIN_PER     = REF_HZ / MAX_RATE_HZ,
  localparam int PW          = $clog2(TIMEOUT_CYC + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleStrobe,
  output logic [PW-1:0] periodEst,
  output logic [1:0]    domain,
  output logic          locked,
  output logic          outOfRange
);
  srtCtl_t ctl;
  logic    periodNear;
  logic    cntExpired;
  logic    estTooFast;
  logic    estValid;

  srtControl #(.LOCK_N(LOCK_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .periodNear(periodNear), .cntExpired(cntExpired), .estTooFast(estTooFast),
    .ctl(ctl), .estValid(estValid), .locked(locked), .outOfRange(outOfRange)
  );

  srtDatapath #(
    .PW(PW), .SHIFT(SHIFT), .TIMEOUT_CYC(TIMEOUT_CYC),
    .MIN_PER(MIN_PER), .TOL_DIV(TOL_DIV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .periodEst(periodEst),
    .periodNear(periodNear), .cntExpired(cntExpired), .estTooFast(estTooFast)
  );

  srtDomain #(
    .PW(PW), .REF_HZ(REF_HZ), .EDGE_A(EDGE_A), .EDGE_B(EDGE_B),
    .EDGE_C(EDGE_C), .HYST_PCT(HYST_PCT)
  ) u_dom (
    .clk(clk), .rstN(rstN), .estValid(estValid),
    .periodEst(periodEst), .domain(domain)
  );
endmodule

// File: tb/sampleRateTracker_test.sv
module sampleRateTracker_test;
  localparam int REF = 4_800_000;      // timeout 960, too-fast limit 87
  localparam int PW  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic [PW-1:0] periodEst;
  logic [1:0] domain;
  logic locked, outOfRange;

  always #5 clk = ~clk;

  sampleRateTracker #(.REF_HZ(REF)) uut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .periodEst(periodEst), .domain(domain), .locked(locked), .outOfRange(outOfRange)
  );

  typedef struct {
    int    est;
    int    dom;
    int    lk;
    int    oor;
    string tag;
  } exp_t;

  exp_t sb[$];
  int nChecks = 0;
  int nFails  = 0;
  int extra   = 0;
  bit finished = 1'b0;

  // reference model state, built from the requirements
  bit mPrimed = 0, mValid = 0, mLocked = 0, mTimed = 0;
  int mEstQ = 0, mLockCnt = 0, mDom = 0;
  int upTh[3] = '{396, 190, 118};   // R7 entry limits for 12/25/40 kHz at 4.8 MHz
  int dnTh[3] = '{404, 193, 121};   // R7 stay limits

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelStrobe(int gap);
    int est, diff, nd;
    if (gap > 960) begin                 // R8
      mTimed = 1; mValid = 0; mLocked = 0; mLockCnt = 0; mPrimed = 1;
    end else if (!mPrimed) begin
      mPrimed = 1;
    end else if (!mValid) begin          // R2
      mEstQ = gap * 16; mValid = 1; mTimed = 0; mLockCnt = 0; mLocked = 0;
    end else begin                       // R3, R4, R5
      est  = mEstQ / 16;
      diff = (gap >= est) ? gap - est : est - gap;
      if (diff * 50 <= est) begin
        if (mLockCnt == 15) mLocked = 1;
        else mLockCnt++;
      end else begin
        mLockCnt = 0; mLocked = 0;
      end
      mEstQ = mEstQ - mEstQ / 16 + gap;
    end
    if (mValid) begin                    // R6, R7
      est = mEstQ / 16;
      nd  = 0;
      for (int b = 0; b < 3; b++)
        nd += (mDom > b) ? int'(est <= dnTh[b]) : int'(est <= upTh[b]);
      mDom = nd;
    end
  endtask

  // driver: strobe after a gap and push the expected result
  task automatic pulse(int gap, string tag);
    exp_t e;
    repeat (gap - 1) @(negedge clk);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    modelStrobe(gap + extra);
    extra = 0;
    e.est = mEstQ / 16;
    e.dom = mDom;
    e.lk  = int'(mLocked);
    e.oor = int'(mTimed || (mValid && (mEstQ / 16) < 87));   // R9
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    extra += n;
  endtask

  task automatic run(int n, int gap, string tag);
    for (int i = 0; i < n; i++) pulse(gap, tag);
  endtask

  // monitor: compare one cycle after the domain register settles
  initial begin
    forever begin
      @(posedge clk);
      if (sampleStrobe === 1'b1) begin
        @(negedge clk);
        @(negedge clk);
        if (sb.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL scoreboard empty actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "periodEst", int'(periodEst), e.est);
          check(e.tag, "domain", int'(domain), e.dom);
          check(e.tag, "locked", int'(locked), e.lk);
          check(e.tag, "outOfRange", int'(outOfRange), e.oor);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "periodEst", int'(periodEst), 0);
    check("R1", "domain", int'(domain), 0);
    check("R1", "locked", int'(locked), 0);
    check("R1", "outOfRange", int'(outOfRange), 0);
    rstN = 1'b1;
    idle(2);
    check("R1", "locked after release", int'(locked), 0);

    // R2 prime and seed, R4 lock after 16 matches, R6 top band at 44 kHz
    pulse(20, "R2_prime");
    pulse(109, "R2_seed");
    run(15, 109, "R4_count");
    check("R4", "not yet locked after 15", int'(locked), 0);
    pulse(109, "R4_lock");
    idle(2);
    check("R4", "locked after 16", int'(locked), 1);
    check("R6", "band at 109 cycles", int'(domain), 3);

    // R3 jitter smoothing
    for (int i = 0; i < 30; i++) pulse((i % 2) ? 108 : 110, "R3_jitter");

    // R5 rate step breaks lock, estimate glides toward 395
    pulse(395, "R5_step");
    idle(2);
    check("R5", "lock after jump", int'(locked), 0);
    run(100, 395, "R6_glide");
    idle(2);
    check("R6", "band at 395 cycles", int'(domain), 1);

    // R7 hysteresis around the 12 kHz edge
    run(55, 402, "R7_hold_up");
    idle(2);
    check("R7", "band held at 402", int'(domain), 1);
    run(55, 410, "R7_leave");
    idle(2);
    check("R7", "band left at 410", int'(domain), 0);
    run(55, 398, "R7_hold_dn");
    idle(2);
    check("R7", "band held at 398", int'(domain), 0);
    run(55, 390, "R7_enter");
    idle(2);
    check("R7", "band entered at 390", int'(domain), 1);
    check("R4", "relocked at 390", int'(locked), 1);

    // R8 timeout while idle, R10 values hold
    idle(1000);
    check("R8", "locked on timeout", int'(locked), 0);
    check("R8", "outOfRange on timeout", int'(outOfRange), 1);
    check("R10", "domain held", int'(domain), 1);
    check("R10", "periodEst held", int'(periodEst), mEstQ / 16);
    pulse(10, "R8_restart");
    pulse(390, "R8_reseed");

    // R9 rate above the top limit
    run(100, 80, "R9_fast");
    idle(2);
    check("R9", "outOfRange when too fast", int'(outOfRange), 1);
    check("R6", "band when fast", int'(domain), 3);

    // R8 boundary: 960 measured, 961 times out
    pulse(960, "R8_edge960");
    pulse(961, "R8_edge961");
    idle(2);
    check("R8", "outOfRange after 961", int'(outOfRange), 1);
    pulse(100, "R8_prime");
    pulse(100, "R8_seed");
    idle(2);
    check("R8", "outOfRange cleared on seed", int'(outOfRange), 0);

    idle(4);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule